// File: doc/BRIEF.md
# Overlapped Register Window File

This block is a register file for a processor whose procedure calls switch to a fresh set of registers instead of saving them to memory. Software always uses 32 logical register numbers. A current window pointer maps them onto a larger circular physical array. Logical 1 to 9 are globals that every window sees in the same place. Logical 10 to 31 come from the active window. A window is 16 physical registers plus 6 that it borrows from its neighbour.

Neighbouring windows overlap. The six highest registers of a caller are the same physical cells as the six lowest registers of the procedure it calls, so arguments and results pass with no copying. Logical 0 is a constant zero. There are two combinational read ports and one write port, all addressed by logical number. A call input and a return input move the window pointer.

The block tracks how many windows are resident. It refuses a call when all windows are in use and a return when only one is left, and raises a flag in each case. Spilling and filling windows in memory is left to the surrounding logic.

Top module: `ovl_regfile`

## Requirements
- R1: After synchronous reset the window pointer is 0, the resident-window count is 1, both flags are low and every logical register reads 0.
- R2: Logical register 0 always reads 0 on both read ports, and a write to it changes no register.
- R3: Logical registers 1 to 9 map to the same physical register in every window, so a value written in one window reads back unchanged in any other window.
- R4: Logical registers 16 to 25 are private to a window: a write in one window does not change the same logical number in a different window.
- R5: After a call, the callee's logical registers 10 to 15 are the same physical registers as the caller's logical registers 26 to 31, in the same order.
- R6: An accepted call decrements the window pointer modulo NWIN and adds one to the resident count. An accepted return increments the window pointer modulo NWIN and subtracts one from the resident count.
- R7: A call while NWIN windows are resident raises `win_overflow` in the same cycle, and the window pointer and resident count stay unchanged.
- R8: A return while one window is resident raises `win_underflow` in the same cycle, and the window pointer and resident count stay unchanged.
- R9: A write in the same cycle as a call or a return goes to the window that was active before the pointer moves.
- R10: Call and return asserted together are a no-op: the pointer does not move and neither flag rises.
- R11: Window overlap is circular. The window reached with pointer value 1, whose high registers 26 to 31 share cells with the low registers 10 to 15 of pointer value 0, closes the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 5 | Logical register number, read port A |
| rd_data_a | output | DATA_W | Read data A, combinational |
| rd_addr_b | input | 5 | Logical register number, read port B |
| rd_data_b | output | DATA_W | Read data B, combinational |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register number to write |
| wr_data | input | DATA_W | Write data |
| call_i | input | 1 | Procedure call: move to the next window |
| ret_i | input | 1 | Procedure return: move back to the previous window |
| cwp_o | output | CWP_W | Current window pointer |
| win_overflow | output | 1 | Call refused because all windows are resident |
| win_underflow | output | 1 | Return refused because one window is resident |

## Verification
The bench builds the block with NWIN = 4 and DATA_W = 16. Four windows make the ring short enough that three calls fill it. The same run can then reach overflow, wrap the pointer from 0 down to its top value, and show the last window's high registers landing on the first window's low registers. Globals, private registers and the shared groups are all checked against fixed physical cells that the bench works out by hand from the mapping rule.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    localparam int unsigned LOG_W    = 5;
    localparam int unsigned NUM_GLOB = 10;
    localparam int unsigned WIN_SPAN = 16;

    typedef enum logic [1:0] {
        WIN_HOLD = 2'd0,
        WIN_CALL = 2'd1,
        WIN_RET  = 2'd2
    } win_op_e;

    typedef struct packed {
        logic ovf;
        logic unf;
    } win_flags_t;

    // Logical -> physical index. Globals pass through; windowed registers
    // use a window slot that advances as the pointer decrements.
    function automatic int unsigned map_phys(input int unsigned lreg,
                                             input int unsigned cwp,
                                             input int unsigned nwin);
        int unsigned slot;
        int unsigned off;
        if (lreg < NUM_GLOB) begin
            return lreg;
        end
        slot = (nwin - cwp) % nwin;
        off  = (slot * WIN_SPAN + (lreg - NUM_GLOB)) % (WIN_SPAN * nwin);
        return NUM_GLOB + off;
    endfunction

endpackage

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
    import wrf_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int CWP_W  = 3,
    parameter int PHYS_W = 8
) (
    input  logic [LOG_W-1:0]  lreg,
    input  logic [CWP_W-1:0]  cwp,
    output logic [PHYS_W-1:0] phys
);

    int unsigned idx;

    always_comb begin
        idx  = map_phys(32'(lreg), 32'(cwp), NWIN);
        phys = PHYS_W'(idx);
    end

endmodule

// File: rtl/wrf_window_ctrl.sv
module wrf_window_ctrl
    import wrf_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int CWP_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             call_i,
    input  logic             ret_i,
    output logic [CWP_W-1:0] cwp_o,
    output win_flags_t       flags_o
);

    localparam int CNT_W = $clog2(NWIN + 1);

    logic [CWP_W-1:0] cwp_q;
    logic [CNT_W-1:0] resid_q;
    win_op_e          op;
    logic             full;
    logic             last;

    always_comb begin
        op = WIN_HOLD;
        if (call_i && !ret_i) op = WIN_CALL;
        else if (ret_i && !call_i) op = WIN_RET;
    end

    assign full        = (resid_q == CNT_W'(NWIN));
    assign last        = (resid_q == CNT_W'(1));
    assign flags_o.ovf = (op == WIN_CALL) && full;
    assign flags_o.unf = (op == WIN_RET) && last;
    assign cwp_o       = cwp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp_q   <= '0;
            resid_q <= CNT_W'(1);
        end else begin
            case (op)
                WIN_CALL: if (!full) begin
                    cwp_q   <= (cwp_q == '0) ? CWP_W'(NWIN - 1) : cwp_q - 1'b1;
                    resid_q <= resid_q + 1'b1;
                end
                WIN_RET: if (!last) begin
                    cwp_q   <= (cwp_q == CWP_W'(NWIN - 1)) ? '0 : cwp_q + 1'b1;
                    resid_q <= resid_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R7
    ovf_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        flags_o.ovf |=> ($stable(cwp_q) && $stable(resid_q)));

    // R8
    unf_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        flags_o.unf |=> ($stable(cwp_q) && $stable(resid_q)));

    // R6
    call_count_chk: assert property (@(posedge clk) disable iff (rst)
        (call_i && !ret_i && !flags_o.ovf) |=> (resid_q == $past(resid_q) + 1'b1));

    // R6
    ret_count_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !call_i && !flags_o.unf) |=> (resid_q == $past(resid_q) - 1'b1));

    // R10
    both_noop_chk: assert property (@(posedge clk) disable iff (rst)
        (call_i && ret_i) |-> (!flags_o.ovf && !flags_o.unf) ##1 $stable(cwp_q));

    // R7
    resid_range_chk: assert property (@(posedge clk) disable iff (rst)
        (resid_q >= CNT_W'(1)) && (resid_q <= CNT_W'(NWIN)));

endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
    parameter int DATA_W = 32,
    parameter int PHYS_N = 138,
    parameter int PHYS_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PHYS_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PHYS_W-1:0] raddr_a,
    input  logic [PHYS_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] mem_q [PHYS_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PHYS_N; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

    // R2
    zero_cell_chk: assert property (@(posedge clk) disable iff (rst)
        mem_q[0] == '0);

endmodule

// File: rtl/ovl_regfile.sv
module ovl_regfile
    import wrf_pkg::*;
#(
    parameter int  DATA_W = 32,
    parameter int  NWIN   = 8,
    localparam int CWP_W  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [4:0]        rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              call_i,
    input  logic              ret_i,
    output logic [CWP_W-1:0]  cwp_o,
    output logic              win_overflow,
    output logic              win_underflow
);

    localparam int PHYS_N = NUM_GLOB + WIN_SPAN * NWIN;
    localparam int PHYS_W = $clog2(PHYS_N);
    localparam int NPORT  = 3;

    logic [CWP_W-1:0]  cwp;
    win_flags_t        flags;
    logic [4:0]        lreg_all [NPORT];
    logic [PHYS_W-1:0] phys_all [NPORT];
    logic [DATA_W-1:0] raw_a;
    logic [DATA_W-1:0] raw_b;
    logic              wr_live;

    wrf_window_ctrl #(.NWIN(NWIN), .CWP_W(CWP_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .call_i  (call_i),
        .ret_i   (ret_i),
        .cwp_o   (cwp),
        .flags_o (flags)
    );

    assign lreg_all[0] = rd_addr_a;
    assign lreg_all[1] = rd_addr_b;
    assign lreg_all[2] = wr_addr;

    // The write port maps with the registered pointer, i.e. the pre-move window.
    for (genvar p = 0; p < NPORT; p++) begin : g_map
        wrf_addr_map #(.NWIN(NWIN), .CWP_W(CWP_W), .PHYS_W(PHYS_W)) u_map (
            .lreg (lreg_all[p]),
            .cwp  (cwp),
            .phys (phys_all[p])
        );
    end

    assign wr_live = wr_en && (wr_addr != 5'd0);

    wrf_store #(.DATA_W(DATA_W), .PHYS_N(PHYS_N), .PHYS_W(PHYS_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_live),
        .waddr   (phys_all[2]),
        .wdata   (wr_data),
        .raddr_a (phys_all[0]),
        .raddr_b (phys_all[1]),
        .rdata_a (raw_a),
        .rdata_b (raw_b)
    );

    assign rd_data_a     = (rd_addr_a == 5'd0) ? '0 : raw_a;
    assign rd_data_b     = (rd_addr_b == 5'd0) ? '0 : raw_b;
    assign cwp_o         = cwp;
    assign win_overflow  = flags.ovf;
    assign win_underflow = flags.unf;

    // R9
    wr_window_chk: assert property (@(posedge clk) disable iff (rst)
        (call_i || ret_i) |-> (phys_all[2] == PHYS_W'(map_phys(32'(wr_addr), 32'(cwp_o), NWIN))));

    // R3
    glob_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_addr < 5'd10) |-> (phys_all[2] == PHYS_W'(wr_addr)));

endmodule

// File: tb/ovl_regfile_test.sv
module ovl_regfile_test;

    localparam int DW   = 16;
    localparam int NW   = 4;
    localparam int CW   = 2;
    localparam int NV   = 27;

    localparam logic [1:0] OP_W = 2'd0;
    localparam logic [1:0] OP_R = 2'd1;
    localparam logic [1:0] OP_C = 2'd2;
    localparam logic [1:0] OP_T = 2'd3;

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [3:0] rq,
                                       input logic [4:0] rg, input logic [15:0] d);
        return {op, rq, rg, 5'd0, d};
    endfunction

    // For calls/returns the data field holds the expected pointer afterwards.
    localparam logic [31:0] VEC [NV] = '{
        mk(OP_W, 4'd3,  5'd1,  16'h1111),
        mk(OP_W, 4'd2,  5'd0,  16'h00FF),   // R2 write to zero discarded
        mk(OP_R, 4'd2,  5'd0,  16'h0000),   // R2
        mk(OP_R, 4'd3,  5'd1,  16'h1111),   // R3
        mk(OP_W, 4'd5,  5'd10, 16'hA010),
        mk(OP_W, 4'd4,  5'd20, 16'hA020),
        mk(OP_W, 4'd5,  5'd26, 16'hA026),
        mk(OP_C, 4'd6,  5'd0,  16'd3),      // R6 0 -> 3
        mk(OP_R, 4'd3,  5'd1,  16'h1111),   // R3
        mk(OP_R, 4'd4,  5'd20, 16'h0000),   // R4 new window private
        mk(OP_R, 4'd5,  5'd10, 16'hA026),   // R5 callee low = caller high
        mk(OP_W, 4'd4,  5'd20, 16'hB020),
        mk(OP_W, 4'd5,  5'd31, 16'hB031),
        mk(OP_T, 4'd6,  5'd0,  16'd0),      // R6 3 -> 0
        mk(OP_R, 4'd4,  5'd20, 16'hA020),   // R4 unchanged by callee
        mk(OP_R, 4'd5,  5'd26, 16'hA026),   // R5
        mk(OP_R, 4'd5,  5'd10, 16'hA010),   // R5
        mk(OP_W, 4'd3,  5'd5,  16'h0555),
        mk(OP_C, 4'd6,  5'd0,  16'd3),      // R6
        mk(OP_R, 4'd3,  5'd5,  16'h0555),   // R3
        mk(OP_C, 4'd6,  5'd0,  16'd2),      // R6
        mk(OP_R, 4'd5,  5'd15, 16'hB031),   // R5 order kept
        mk(OP_C, 4'd6,  5'd0,  16'd1),      // R6
        mk(OP_R, 4'd11, 5'd26, 16'hA010),   // R11 ring closes on first window
        mk(OP_T, 4'd6,  5'd0,  16'd2),
        mk(OP_T, 4'd6,  5'd0,  16'd3),
        mk(OP_T, 4'd6,  5'd0,  16'd0)       // R6 3 -> 0 wraps
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [4:0]    rd_addr_a = '0;
    logic [DW-1:0] rd_data_a;
    logic [4:0]    rd_addr_b = '0;
    logic [DW-1:0] rd_data_b;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          call_i = 1'b0;
    logic          ret_i = 1'b0;
    logic [CW-1:0] cwp_o;
    logic          win_overflow;
    logic          win_underflow;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ovl_regfile #(.DATA_W(DW), .NWIN(NW)) uut (
        .clk(clk), .rst(rst),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .call_i(call_i), .ret_i(ret_i), .cwp_o(cwp_o),
        .win_overflow(win_overflow), .win_underflow(win_underflow)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic rd(input string rq, input logic [4:0] r, input logic [15:0] exp);
        @(negedge clk);
        rd_addr_a = r;
        rd_addr_b = r;
        #1;
        chk(rq, 32'(rd_data_a), 32'(exp));
        chk(rq, 32'(rd_data_b), 32'(exp));
    endtask

    task automatic wr(input logic [4:0] r, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = r; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Drive call/return for one cycle; check flags before the edge, pointer after.
    task automatic mv(input string rq, input logic c, input logic t,
                      input logic eo, input logic eu, input logic [CW-1:0] ecwp);
        @(negedge clk);
        call_i = c; ret_i = t;
        #1;
        chk(rq, 32'(win_overflow), 32'(eo));
        chk(rq, 32'(win_underflow), 32'(eu));
        @(posedge clk); #1;
        call_i = 1'b0; ret_i = 1'b0;
        chk(rq, 32'(cwp_o), 32'(ecwp));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        #1;
        chk("R1", 32'(cwp_o), 32'd0);
        chk("R1", 32'(win_overflow), 32'd0);
        chk("R1", 32'(win_underflow), 32'd0);
        rd("R1", 5'd16, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [3:0]  rq;
            logic [4:0]  rg;
            logic [15:0] d;
            string       tag;
            op  = VEC[i][31:30];
            rq  = VEC[i][29:26];
            rg  = VEC[i][25:21];
            d   = VEC[i][15:0];
            tag = $sformatf("R%0d", rq);
            case (op)
                OP_W: wr(rg, d);
                OP_R: rd(tag, rg, d);
                OP_C: mv(tag, 1'b1, 1'b0, 1'b0, 1'b0, CW'(d));
                default: mv(tag, 1'b0, 1'b1, 1'b0, 1'b0, CW'(d));
            endcase
        end

        // R8 return with a single resident window
        mv("R8", 1'b0, 1'b1, 1'b0, 1'b1, 2'd0);
        // R10 call and return together: no flag, no move
        mv("R10", 1'b1, 1'b1, 1'b0, 1'b0, 2'd0);

        // R9 write during a call lands in the caller's window
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd16; wr_data = 16'hC016; call_i = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; call_i = 1'b0;
        chk("R9", 32'(cwp_o), 32'd3);
        rd("R9", 5'd16, 16'h0000);
        // R9 write during a return lands in the callee's window
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd17; wr_data = 16'hD017; ret_i = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; ret_i = 1'b0;
        rd("R9", 5'd16, 16'hC016);
        rd("R9", 5'd17, 16'h0000);
        mv("R9", 1'b1, 1'b0, 1'b0, 1'b0, 2'd3);
        rd("R9", 5'd17, 16'hD017);

        // R7 fill the ring then call once more
        mv("R7", 1'b1, 1'b0, 1'b0, 1'b0, 2'd2);
        mv("R7", 1'b1, 1'b0, 1'b0, 1'b0, 2'd1);
        mv("R7", 1'b1, 1'b0, 1'b1, 1'b0, 2'd1);
        mv("R7", 1'b0, 1'b1, 1'b0, 1'b0, 2'd2);

        // R1 reset in mid-run clears pointer and contents
        do_reset();
        #1;
        chk("R1", 32'(cwp_o), 32'd0);
        rd("R1", 5'd1, 16'h0000);
        rd("R1", 5'd10, 16'h0000);
        mv("R1", 1'b0, 1'b1, 1'b0, 1'b1, 2'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule